// File: doc/BRIEF.md
# Bitmap Border Colour Search Engine

This unit walks one row of a packed bitmap framebuffer, pixel by pixel, from a chosen start coordinate. It stops on the first pixel that is equal to a reference colour, or on the first pixel that differs from it. When no pixel qualifies, the walk ends at the left or right screen edge. Pixels are fetched one byte at a time through a read port with a request/valid handshake and variable latency. Each returned byte yields exactly one pixel evaluation.

Software loads the operand registers in any order through a small write-only register port. A write to the launch register starts the run. The result is shown directly on output pins:
- a busy level,
- a found bit,
- the x coordinate where the walk stopped,
- a sticky interrupt, cleared by writing 1.

The screen width and height are parameters and must be powers of two.

Register map (address on `regAddr`, data on `regWdata`):
- 0: start x.
- 1: start y.
- 2: reference colour.
- 3: settings.
- 4: launch, with any data.
- 5: interrupt clear, bit 0.

Top module: `border_search`

## Requirements
- R1: Registers 0 to 3 may be written in any order and are copied into the engine when register 4 is written while idle. A register-4 write while busy is ignored. Writes to registers 0 to 3 during a run do not change that run.
- R2: `busy` is 1 from the clock edge that takes the launch write until the edge that completes the run, and 0 otherwise.
- R3: The interrupt flag is set at the completion edge and drives `irq` high. It is held until a write to register 5 with bit 0 = 1 clears it. A write with bit 0 = 0 leaves it set. When a clear and a completion fall on the same edge, the flag ends up set.
- R4: `found` is 1 after a run that met a qualifying pixel and 0 after a run that reached the screen edge without one.
- R5: `borderX` is rewritten at the end of every run. It takes the x of the qualifying pixel, or the edge x (SCREEN_W-1 or 0) when nothing qualified.
- R6: The start x is reduced modulo SCREEN_W and the start y modulo SCREEN_H before use. With a 256-pixel width, x is ANDed with 255.
- R7: Settings bit 0 selects the direction: 0 walks toward increasing x and 1 toward decreasing x. The start pixel is the first one examined.
- R8: Settings bit 1 selects the stop condition: 1 stops on a pixel equal to the reference, 0 on a pixel different from it. The reference is cut to the pixel depth.
- R9: Settings bits 3:2 select the depth: 0 = 2 bits per pixel, 1 = 4, 2 or 3 = 8. Pixels are packed MSB first. The byte address is y*SCREEN_W*bpp/8 + x*bpp/8.
- R10: One one-cycle `rdReq` pulse is issued per examined pixel. The next request follows only after `rdValid` returns the previous byte, so the read count equals the number of pixels examined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| rdReq | output | 1 | Read request pulse |
| rdAddr | output | log2(SCREEN_W*SCREEN_H) | Byte address of the read |
| rdValid | input | 1 | Read data valid |
| rdData | input | 8 | Returned byte |
| busy | output | 1 | Run in progress |
| found | output | 1 | Last run met a qualifying pixel |
| borderX | output | log2(SCREEN_W) | X where the last run stopped |
| irq | output | 1 | Completion interrupt, high while the flag is set |

## Verification
Two functions can coincide in one cycle: setting the completion flag and a software clear of that same flag. The bench provokes this with a run that stops on its start pixel at a memory latency of one. The clear write is placed so that it is sampled on exactly the edge that consumes the returned byte. The case passes only if `irq` reads 1 afterwards and a later clear then brings it to 0. A second overlap, a relaunch and operand rewrites during a long run, is judged by comparing the finished result with the values captured at launch.

// File: rtl/border_search_pkg.sv
package border_search_pkg;

  localparam logic [2:0] REG_START_X = 3'd0;
  localparam logic [2:0] REG_START_Y = 3'd1;
  localparam logic [2:0] REG_REF     = 3'd2;
  localparam logic [2:0] REG_CFG     = 3'd3;
  localparam logic [2:0] REG_LAUNCH  = 3'd4;
  localparam logic [2:0] REG_IRQCLR  = 3'd5;

  typedef enum logic [1:0] {
    DEPTH_2  = 2'd0,
    DEPTH_4  = 2'd1,
    DEPTH_8  = 2'd2,
    DEPTH_8B = 2'd3
  } depthSel_t;

  typedef struct packed {
    logic load;    // snapshot operands, start position
    logic step;    // advance to next pixel
    logic finish;  // write results
  } srchStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } srchState_t;

endpackage

// File: rtl/border_search_ctrl.sv
module border_search_ctrl
  import border_search_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic        clearBit,
  input  logic        rdValid,
  input  logic        hit,
  input  logic        atEdge,
  output srchStrobe_t strobe,
  output logic        rdReq,
  output logic        busy,
  output logic        irq
);

  srchState_t state, stateNext;
  logic irqFlag;
  logic launchWr, clearWr;

  assign launchWr = regWe && (regAddr == REG_LAUNCH);
  assign clearWr  = regWe && (regAddr == REG_IRQCLR) && clearBit;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    rdReq     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (launchWr) begin
          strobe.load = 1'b1;
          stateNext   = ST_REQ;
        end
      end
      ST_REQ: begin
        rdReq     = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (rdValid) begin
          if (hit || atEdge) begin
            strobe.finish = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            strobe.step = 1'b1;
            stateNext   = ST_REQ;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      irqFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.finish)
        irqFlag <= 1'b1;
      else if (clearWr)
        irqFlag <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);
  assign irq  = irqFlag;

endmodule

// File: rtl/border_search_dp.sv
module border_search_dp
  import border_search_pkg::*;
#(
  parameter int SCREEN_W = 256,
  parameter int SCREEN_H = 256,
  parameter int DATA_W   = 16,
  localparam int X_W     = $clog2(SCREEN_W),
  localparam int Y_W     = $clog2(SCREEN_H),
  localparam int ADDR_W  = X_W + Y_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  srchStrobe_t       strobe,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              hit,
  output logic              atEdge,
  output logic              found,
  output logic [X_W-1:0]    borderX
);

  logic [X_W-1:0] startXReg, curX;
  logic [Y_W-1:0] startYReg, curY;
  logic [7:0]     refReg, refR;
  logic [3:0]     cfgReg;
  logic           dirR, eqR;
  depthSel_t      depthR, depthCfg;
  logic [7:0]     pix, refCut, shifted2;
  logic           unusedData;

  assign unusedData = ^regWdata;
  assign depthCfg   = depthSel_t'(cfgReg[3:2]);

  // operand registers, truncation realises the modulo masking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startXReg <= '0;
      startYReg <= '0;
      refReg    <= '0;
      cfgReg    <= '0;
    end else if (regWe) begin
      case (regAddr)
        REG_START_X: startXReg <= regWdata[X_W-1:0];
        REG_START_Y: startYReg <= regWdata[Y_W-1:0];
        REG_REF:     refReg    <= regWdata[7:0];
        REG_CFG:     cfgReg    <= regWdata[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (depthCfg)
      DEPTH_2: refCut = {6'b0, refReg[1:0]};
      DEPTH_4: refCut = {4'b0, refReg[3:0]};
      default: refCut = refReg;
    endcase
  end

  // working state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curX    <= '0;
      curY    <= '0;
      refR    <= '0;
      dirR    <= 1'b0;
      eqR     <= 1'b0;
      depthR  <= DEPTH_8;
      found   <= 1'b0;
      borderX <= '0;
    end else begin
      if (strobe.load) begin
        curX   <= startXReg;
        curY   <= startYReg;
        refR   <= refCut;
        dirR   <= cfgReg[0];
        eqR    <= cfgReg[1];
        depthR <= depthCfg;
      end else if (strobe.step) begin
        curX <= dirR ? curX - 1'b1 : curX + 1'b1;
      end
      if (strobe.finish) begin
        found   <= hit;
        borderX <= curX;
      end
    end
  end

  // byte address of current pixel
  always_comb begin
    case (depthR)
      DEPTH_2: rdAddr = {2'b0, curY, curX[X_W-1:2]};
      DEPTH_4: rdAddr = {1'b0, curY, curX[X_W-1:1]};
      default: rdAddr = {curY, curX};
    endcase
  end

  // MSB-first pixel extraction
  assign shifted2 = rdData >> {~curX[1:0], 1'b0};

  always_comb begin
    case (depthR)
      DEPTH_2: pix = {6'b0, shifted2[1:0]};
      DEPTH_4: pix = {4'b0, curX[0] ? rdData[3:0] : rdData[7:4]};
      default: pix = rdData;
    endcase
  end

  assign hit    = eqR ? (pix == refR) : (pix != refR);
  assign atEdge = dirR ? (curX == '0) : (curX == {X_W{1'b1}});

endmodule

// File: rtl/border_search.sv
module border_search
  import border_search_pkg::*;
#(
  parameter int SCREEN_W = 256,
  parameter int SCREEN_H = 256,
  localparam int X_W     = $clog2(SCREEN_W),
  localparam int Y_W     = $clog2(SCREEN_H),
  localparam int ADDR_W  = X_W + Y_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWdata,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [7:0]        rdData,
  output logic              busy,
  output logic              found,
  output logic [X_W-1:0]    borderX,
  output logic              irq
);

  srchStrobe_t strobe;
  logic hit, atEdge;

  border_search_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .clearBit (regWdata[0]),
    .rdValid  (rdValid),
    .hit      (hit),
    .atEdge   (atEdge),
    .strobe   (strobe),
    .rdReq    (rdReq),
    .busy     (busy),
    .irq      (irq)
  );

  border_search_dp #(
    .SCREEN_W (SCREEN_W),
    .SCREEN_H (SCREEN_H),
    .DATA_W   (16)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobe   (strobe),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .hit      (hit),
    .atEdge   (atEdge),
    .found    (found),
    .borderX  (borderX)
  );

endmodule

// File: rtl/border_search_chk.sv
module border_search_chk #(
  parameter int X_W = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           regWe,
  input logic [2:0]     regAddr,
  input logic [15:0]    regWdata,
  input logic           rdReq,
  input logic           busy,
  input logic           found,
  input logic [X_W-1:0] borderX,
  input logic           irq
);

  logic launchIdle, clearOne;
  assign launchIdle = regWe && (regAddr == 3'd4) && !busy;
  assign clearOne   = regWe && (regAddr == 3'd5) && regWdata[0];

  a_r2_busy_on_launch: assert property (@(posedge clk) disable iff (!rstN)
    launchIdle |=> busy);

  a_r10_req_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> busy);

  a_r10_req_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  a_r3_irq_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);

  a_r3_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clearOne) |=> irq);

  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(busy) |-> ($stable(borderX) && $stable(found)));

endmodule

bind border_search border_search_chk #(.X_W(X_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .rdReq    (rdReq),
  .busy     (busy),
  .found    (found),
  .borderX  (borderX),
  .irq      (irq)
);

// File: tb/tb_border_search.sv
`timescale 1ns/1ps
module tb_border_search;

  localparam int W = 256;
  localparam int H = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        rdReq;
  logic [15:0] rdAddr;
  logic        rdValid = 1'b0;
  logic [7:0]  rdData = '0;
  logic        busy, found, irq;
  logic [7:0]  borderX;

  int checks = 0;
  int fails  = 0;
  int latency = 1;
  int readCount = 0;
  int firstAddr = -1;
  int fillVal = 0;
  int markAddr [4];
  int markVal  [4];

  always #2.5 clk = ~clk;

  border_search #(.SCREEN_W(W), .SCREEN_H(H)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .busy(busy), .found(found),
    .borderX(borderX), .irq(irq)
  );

  function automatic int memByte(int a);
    for (int i = 0; i < 4; i++)
      if (markAddr[i] == a) return markVal[i];
    return fillVal;
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      rdValid = 1'b0;
      if (rdReq) begin
        int a;
        a = int'(rdAddr);
        if (readCount == 0) firstAddr = a;
        readCount++;
        repeat (latency) @(negedge clk);
        rdData  = 8'(memByte(a));
        rdValid = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input int a, input int d);
    regAddr  = 3'(a);
    regWdata = 16'(d);
    regWe    = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic clearMarks();
    for (int i = 0; i < 4; i++) begin
      markAddr[i] = -1;
      markVal[i]  = 0;
    end
  endtask

  // reference walk built from R4..R9
  task automatic model(input int sx, input int sy, input int refc, input int cfg,
                       output int expFound, output int expX, output int expReads,
                       output int expFirst);
    int bpp, ppb, x, y, mask, a, b, sh, p, depth;
    bit hitNow;
    depth = (cfg >> 2) & 3;
    bpp = (depth == 0) ? 2 : (depth == 1) ? 4 : 8;
    ppb = 8 / bpp;
    mask = (1 << bpp) - 1;
    x = sx & (W - 1);
    y = sy & (H - 1);
    expReads = 0;
    expFirst = y * (W / ppb) + x / ppb;
    forever begin
      a = y * (W / ppb) + x / ppb;
      b = memByte(a);
      sh = (ppb - 1 - (x % ppb)) * bpp;
      p = (b >> sh) & mask;
      expReads++;
      hitNow = (cfg & 2) ? (p == (refc & mask)) : (p != (refc & mask));
      if (hitNow) begin expFound = 1; expX = x; return; end
      if (((cfg & 1) && x == 0) || (!(cfg & 1) && x == W - 1)) begin
        expFound = 0; expX = x; return;
      end
      x = (cfg & 1) ? x - 1 : x + 1;
    end
  endtask

  task automatic runSearch(input string name, input int sx, input int sy,
                           input int refc, input int cfg, input int lat,
                           input bit meddle);
    int eF, eX, eR, eA, n;
    model(sx, sy, refc, cfg, eF, eX, eR, eA);
    latency = lat;
    readCount = 0;
    firstAddr = -1;
    writeReg(3, cfg);
    writeReg(0, sx);
    writeReg(2, refc);
    writeReg(1, sy);
    writeReg(4, 0);
    check(busy == 1'b1, {name, " R2 busy after launch"}, busy, 1);
    if (meddle) begin
      writeReg(0, 200);
      writeReg(2, 0);
      writeReg(4, 0);
      check(busy == 1'b1, {name, " R1 still busy"}, busy, 1);
    end
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    check(busy == 1'b0, {name, " R2 busy drops"}, busy, 0);
    check(int'(found) == eF, {name, " R4 found"}, found, eF);
    check(int'(borderX) == eX, {name, " R5 borderX"}, borderX, eX);
    check(readCount == eR, {name, " R10 read count"}, readCount, eR);
    check(firstAddr == eA, {name, " R9 first address"}, firstAddr, eA);
    check(irq == 1'b1, {name, " R3 irq set"}, irq, 1);
    writeReg(5, 1);
    check(irq == 1'b0, {name, " R3 irq cleared"}, irq, 0);
  endtask

  task automatic testReset();
    check(busy == 1'b0, "R2 reset busy", busy, 0);
    check(found == 1'b0, "R4 reset found", found, 0);
    check(borderX == 8'd0, "R5 reset borderX", borderX, 0);
    check(irq == 1'b0, "R3 reset irq", irq, 0);
    check(rdReq == 1'b0, "R10 reset rdReq", rdReq, 0);
  endtask

  task automatic testEqualRight();
    clearMarks(); fillVal = 8'h00;
    markAddr[0] = 3 * 256 + 40; markVal[0] = 8'h5A;
    runSearch("R7 R8 8bpp equal right", 10, 3, 8'h5A, 32'h0A, 2, 1'b0);
  endtask

  task automatic testNoMatchRightEdge();
    clearMarks(); fillVal = 8'h00;
    runSearch("R5 8bpp right edge", 250, 9, 8'h77, 32'h0A, 1, 1'b0);
  endtask

  task automatic testDiffLeft4bpp();
    clearMarks(); fillVal = 8'h33;
    markAddr[0] = 7 * 128 + 30; markVal[0] = 8'h3C;
    runSearch("R9 4bpp differ left", 100, 7, 8'h03, 32'h05, 3, 1'b0);
  endtask

  task automatic testMask2bpp();
    clearMarks(); fillVal = 8'h00;
    markAddr[0] = 5 * 64 + 62; markVal[0] = 8'h08;
    runSearch("R6 R9 2bpp masked start", 16'h01F3, 16'h0105, 8'hFE, 32'h02, 1, 1'b0);
  endtask

  task automatic testLeftEdge();
    clearMarks(); fillVal = 8'h00;
    runSearch("R7 8bpp left edge", 5, 0, 8'h11, 32'h0B, 2, 1'b0);
  endtask

  task automatic testStartPixel();
    clearMarks(); fillVal = 8'h20;
    runSearch("R7 start pixel qualifies", 77, 12, 8'h21, 32'h08, 1, 1'b0);
  endtask

  task automatic testClearZero();
    clearMarks(); fillVal = 8'h20;
    latency = 1;
    writeReg(4, 0);
    while (busy) @(negedge clk);
    writeReg(5, 0);
    check(irq == 1'b1, "R3 write of 0 keeps flag", irq, 1);
    writeReg(5, 1);
    check(irq == 1'b0, "R3 write of 1 clears flag", irq, 0);
  endtask

  task automatic testBusyIgnore();
    clearMarks(); fillVal = 8'h00;
    runSearch("R1 busy writes ignored", 0, 2, 8'h99, 32'h0A, 2, 1'b1);
  endtask

  task automatic testSameCycle();
    clearMarks(); fillVal = 8'h20;
    latency = 1;
    writeReg(3, 32'h08);
    writeReg(2, 8'h21);
    writeReg(0, 33);
    writeReg(1, 4);
    writeReg(4, 0);
    @(negedge clk);
    writeReg(5, 1);
    check(busy == 1'b0, "R2 coincident run done", busy, 0);
    check(irq == 1'b1, "R3 set wins over clear", irq, 1);
    check(borderX == 8'd33, "R5 coincident borderX", borderX, 33);
    writeReg(5, 1);
    check(irq == 1'b0, "R3 later clear", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", busy, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clearMarks();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEqualRight();
    testNoMatchRightEdge();
    testDiffLeft4bpp();
    testMask2bpp();
    testLeftEdge();
    testStartPixel();
    testClearZero();
    testBusyIgnore();
    testSameCycle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule